// File: doc/BRIEF.md
# Buffered Queue Control Register

This block is a 16-bit configuration register for a queued serial controller. It holds an enable for the queue-finished interrupt, a wrap enable, a wrap destination select, an end-of-queue pointer and a new-queue pointer. The CPU writes it through a simple write strobe. While the serial sequencer is running, a write goes into a shadow copy. It reaches the active copy only at a boundary that the sequencer signals: the end of a transfer, or the end of the whole queue.

The sequencer sees only the active copy, on dedicated read-only outputs. A CPU read also returns the active copy, never the pending one. When a queue completes, the block sets a finished flag. It also records the interrupt enable that was in force for that queue. The interrupt request is the flag gated by that recorded enable. A write that redirects the sequencer into a subqueue can therefore choose the subqueue's interrupt behaviour, while the queue that is finishing keeps its own.

Top module: `qctl_reg`

## Requirements
- R1: After reset, the read value, every active field, the pending indication, the finished flag and the interrupt request are all zero.
- R2: The field positions are as follows. Bit 15 is the interrupt enable, bit 14 the wrap enable and bit 13 the wrap destination. Bits 11:8 hold the end pointer and bits 3:0 the new pointer. Bits 12 and 7:4 are reserved: they ignore written data and always read 0.
- R3: A write made while `busy` is low reaches the active copy, the interrupt enable included, at the next clock edge. It leaves nothing pending.
- R4: A write made while `busy` is high does not change the active copy. It raises `pending`, which stays high until the buffered value has been fully applied.
- R5: At a transfer boundary (`xferDone` or `queueDone`), a pending write copies the wrap enable, the wrap destination and both pointers into the active copy. `xferDone` alone leaves the active interrupt enable unchanged.
- R6: The buffered interrupt enable reaches the active copy only on `queueDone` (or through an idle write). `pending` clears once both parts have been applied.
- R7: A boundary with nothing pending leaves the active value unchanged.
- R8: `cpuRdData` returns the active value, not the buffered one.
- R9: `queueDone` sets the finished flag and `finClr` clears it. When both occur in the same cycle, the set wins.
- R10: The interrupt request is the finished flag ANDed with the interrupt enable that was active during the queue that just completed. An idle write also updates that enable.
- R11: If a busy write coincides with a boundary, the boundary applies the earlier buffered value, and the new value stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrData | input | 16 | CPU write data |
| busy | input | 1 | Sequencer running |
| xferDone | input | 1 | One transfer finished |
| queueDone | input | 1 | Entry at end pointer transferred |
| finClr | input | 1 | Clear finished flag |
| cpuRdData | output | 16 | Active register value |
| actIrqEn | output | 1 | Active interrupt enable |
| actWrapEn | output | 1 | Active wrap enable |
| actWrapTo | output | 1 | Active wrap destination |
| actEndPtr | output | 4 | Active end pointer |
| actNewPtr | output | 4 | Active new pointer |
| pending | output | 1 | Buffered write not yet fully applied |
| finFlag | output | 1 | Queue finished flag |
| finIrq | output | 1 | Finished interrupt request |

## Verification
The bench uses the package's default 4-bit pointer width. With that width, an all-ones write fills both pointers and exposes every reserved bit at once. The fixed layout allows a reference model to compute each read value directly from the written data. The bench steps the design through three stages: the part of a busy write applied at a transfer boundary, the interrupt-enable part applied at queue completion, and a write landing on a boundary. Together these cover the cycles where the shadow and active copies differ.

// File: rtl/qctl_pkg.sv
package qctl_pkg;
  localparam int REG_W      = 16;
  localparam int PTR_W      = 4;
  localparam int IRQ_BIT    = 15;
  localparam int WRAP_BIT   = 14;
  localparam int WRAPTO_BIT = 13;
  localparam int END_LSB    = 8;
  localparam int NEW_LSB    = 0;

  typedef struct packed {
    logic             irqEn;
    logic             wrapEn;
    logic             wrapTo;
    logic [PTR_W-1:0] endPtr;
    logic [PTR_W-1:0] newPtr;
  } cfg_t;

  typedef struct packed {
    logic wrShadow;
    logic loadDirect;
    logic loadCfg;
    logic loadIrq;
    logic setFlag;
    logic clrFlag;
  } strobe_t;

  function automatic cfg_t unpackCfg(input logic [REG_W-1:0] w);
    cfg_t c;
    c.irqEn  = w[IRQ_BIT];
    c.wrapEn = w[WRAP_BIT];
    c.wrapTo = w[WRAPTO_BIT];
    c.endPtr = w[END_LSB +: PTR_W];
    c.newPtr = w[NEW_LSB +: PTR_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] packCfg(input cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[IRQ_BIT]           = c.irqEn;
    w[WRAP_BIT]          = c.wrapEn;
    w[WRAPTO_BIT]        = c.wrapTo;
    w[END_LSB +: PTR_W]  = c.endPtr;
    w[NEW_LSB +: PTR_W]  = c.newPtr;
    return w;
  endfunction
endpackage

// File: rtl/qctl_seq.sv
module qctl_seq
  import qctl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuWrEn,
  input  logic    busy,
  input  logic    xferDone,
  input  logic    queueDone,
  input  logic    finClr,
  output strobe_t strobes,
  output logic    pending
);
  logic pendCfg, pendIrq;
  logic idleWr, busyWr, boundary;

  always_comb begin
    idleWr   = cpuWrEn && !busy;
    busyWr   = cpuWrEn && busy;
    boundary = xferDone || queueDone;

    strobes.wrShadow   = cpuWrEn;
    strobes.loadDirect = idleWr;
    strobes.loadCfg    = boundary && pendCfg && !idleWr;
    strobes.loadIrq    = queueDone && pendIrq && !idleWr;
    strobes.setFlag    = queueDone;
    strobes.clrFlag    = finClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCfg <= 1'b0;
      pendIrq <= 1'b0;
    end else begin
      if (busyWr) begin
        pendCfg <= 1'b1;
        pendIrq <= 1'b1;
      end else if (idleWr) begin
        pendCfg <= 1'b0;
        pendIrq <= 1'b0;
      end else begin
        if (strobes.loadCfg) pendCfg <= 1'b0;
        if (strobes.loadIrq) pendIrq <= 1'b0;
      end
    end
  end

  assign pending = pendCfg || pendIrq;
endmodule

// File: rtl/qctl_store.sv
module qctl_store
  import qctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [REG_W-1:0] wrWord,
  output cfg_t             active,
  output logic             finFlag,
  output logic             finIrq
);
  cfg_t shadow, wrCfg;
  logic flagEn;

  assign wrCfg = unpackCfg(wrWord);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow  <= '0;
      active  <= '0;
      finFlag <= 1'b0;
      flagEn  <= 1'b0;
    end else begin
      if (strobes.wrShadow) shadow <= wrCfg;

      if (strobes.loadDirect) begin
        active <= wrCfg;
      end else begin
        if (strobes.loadCfg) begin
          active.wrapEn <= shadow.wrapEn;
          active.wrapTo <= shadow.wrapTo;
          active.endPtr <= shadow.endPtr;
          active.newPtr <= shadow.newPtr;
        end
        if (strobes.loadIrq) active.irqEn <= shadow.irqEn;
      end

      if (strobes.setFlag)      finFlag <= 1'b1;
      else if (strobes.clrFlag) finFlag <= 1'b0;

      if (strobes.setFlag)         flagEn <= active.irqEn;
      else if (strobes.loadDirect) flagEn <= wrCfg.irqEn;
    end
  end

  assign finIrq = finFlag && flagEn;
endmodule

// File: rtl/qctl_reg.sv
module qctl_reg
  import qctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrEn,
  input  logic [REG_W-1:0] cpuWrData,
  input  logic             busy,
  input  logic             xferDone,
  input  logic             queueDone,
  input  logic             finClr,
  output logic [REG_W-1:0] cpuRdData,
  output logic             actIrqEn,
  output logic             actWrapEn,
  output logic             actWrapTo,
  output logic [PTR_W-1:0] actEndPtr,
  output logic [PTR_W-1:0] actNewPtr,
  output logic             pending,
  output logic             finFlag,
  output logic             finIrq
);
  strobe_t strobes;
  cfg_t    active;

  qctl_seq uSeq (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .busy(busy),
    .xferDone(xferDone), .queueDone(queueDone), .finClr(finClr),
    .strobes(strobes), .pending(pending)
  );

  qctl_store uStore (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrWord(cpuWrData),
    .active(active), .finFlag(finFlag), .finIrq(finIrq)
  );

  assign cpuRdData = packCfg(active);
  assign actIrqEn  = active.irqEn;
  assign actWrapEn = active.wrapEn;
  assign actWrapTo = active.wrapTo;
  assign actEndPtr = active.endPtr;
  assign actNewPtr = active.newPtr;
endmodule

// File: rtl/qctl_chk.sv
module qctl_chk
  import qctl_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cpuWrEn,
  input logic             busy,
  input logic             xferDone,
  input logic             queueDone,
  input logic             finClr,
  input logic [REG_W-1:0] cpuRdData,
  input logic             pending,
  input logic             finFlag,
  input logic             finIrq
);
  p_reset_zero_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (cpuRdData == '0 && !pending && !finFlag && !finIrq));

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdData[12] == 1'b0 && cpuRdData[7:4] == 4'b0));

  p_idle_direct_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !busy) |=> !pending);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && busy && !xferDone && !queueDone) |=> ($stable(cpuRdData) && pending));

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!queueDone && !(cpuWrEn && !busy)) |=> $stable(cpuRdData[15]));

  p_no_pend_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && !cpuWrEn) |=> $stable(cpuRdData));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    queueDone |=> finFlag);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    finIrq |-> finFlag);
endmodule

bind qctl_reg qctl_chk uChk (
  .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .busy(busy),
  .xferDone(xferDone), .queueDone(queueDone), .finClr(finClr),
  .cpuRdData(cpuRdData), .pending(pending), .finFlag(finFlag), .finIrq(finIrq)
);

// File: tb/sim_qctl_reg.sv
module sim_qctl_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [15:0] cpuWrData = '0;
  logic        busy = 1'b0, xferDone = 1'b0, queueDone = 1'b0, finClr = 1'b0;
  logic [15:0] cpuRdData;
  logic        actIrqEn, actWrapEn, actWrapTo, pending, finFlag, finIrq;
  logic [3:0]  actEndPtr, actNewPtr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qctl_reg u0 (.*);

  typedef struct {
    logic [15:0] rd;
    logic        pend;
    logic        flag;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  localparam logic [15:0] MASK_ALL = 16'hEF0F;
  localparam logic [15:0] MASK_CFG = 16'h6F0F;

  logic [15:0] mShadow = '0, mActive = '0;
  logic        mPendC = 0, mPendI = 0, mFlag = 0, mFlagEn = 0;

  task automatic step(input logic wr, input logic [15:0] d, input logic bsy,
                      input logic xd, input logic qd, input logic clr, input string tag);
    logic [15:0] oldAct;
    exp_t e;
    @(negedge clk);
    cpuWrEn = wr; cpuWrData = d; busy = bsy; xferDone = xd; queueDone = qd; finClr = clr;
    oldAct = mActive;
    if (wr && !bsy) begin
      mActive = d & MASK_ALL;
      mPendC = 0; mPendI = 0;
    end else begin
      if ((xd || qd) && mPendC) begin
        mActive = (mActive & 16'h8000) | (mShadow & MASK_CFG);
        mPendC = 0;
      end
      if (qd && mPendI) begin
        mActive[15] = mShadow[15];
        mPendI = 0;
      end
      if (wr) begin mPendC = 1; mPendI = 1; end
    end
    if (wr) mShadow = d & MASK_ALL;
    if (qd) mFlagEn = oldAct[15];
    else if (wr && !bsy) mFlagEn = d[15];
    if (qd) mFlag = 1;
    else if (clr) mFlag = 0;
    e.rd = mActive; e.pend = mPendC || mPendI; e.flag = mFlag;
    e.irq = mFlag && mFlagEn; e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (cpuRdData !== e.rd || pending !== e.pend || finFlag !== e.flag || finIrq !== e.irq) begin
          errors++;
          $display("FAIL %s: rd=%h pend=%b flag=%b irq=%b expected rd=%h pend=%b flag=%b irq=%b",
                   e.tag, cpuRdData, pending, finFlag, finIrq, e.rd, e.pend, e.flag, e.irq);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (cpuRdData !== 16'h0 || pending !== 1'b0 || finFlag !== 1'b0 || finIrq !== 1'b0 ||
        actIrqEn !== 1'b0 || actEndPtr !== 4'h0 || actNewPtr !== 4'h0) begin
      errors++;
      $display("FAIL R1 reset: rd=%h pend=%b flag=%b irq=%b expected all zero",
               cpuRdData, pending, finFlag, finIrq);
    end
    @(negedge clk); rstN = 1'b1;

    step(1, 16'hFFFF, 0, 0, 0, 0, "R2 R3 all-ones idle write");
    step(0, 16'h0000, 0, 0, 0, 0, "R2 field hold");
    step(1, 16'h0000, 0, 0, 0, 0, "R3 idle write zero");
    step(1, 16'h10F0, 0, 0, 0, 0, "R2 reserved bits ignored");
    step(1, 16'hA35C, 0, 0, 0, 0, "R3 idle write pattern");
    step(1, 16'h4F07, 1, 0, 0, 0, "R4 R8 busy write holds active");
    step(0, 16'h0000, 1, 0, 0, 0, "R4 pending held");
    step(0, 16'h0000, 1, 1, 0, 0, "R5 transfer boundary applies cfg");
    step(0, 16'h0000, 1, 0, 1, 0, "R6 R9 R10 queue end applies enable");
    step(0, 16'h0000, 1, 1, 0, 0, "R7 boundary with nothing pending");
    step(0, 16'h0000, 1, 0, 0, 1, "R9 flag clear");
    step(1, 16'h8123, 1, 0, 0, 0, "R4 busy write subqueue");
    step(0, 16'h0000, 1, 0, 1, 0, "R10 primary keeps own enable");
    step(0, 16'h0000, 1, 0, 1, 0, "R10 subqueue enable in force");
    step(0, 16'h0000, 1, 0, 1, 1, "R9 set wins over clear");
    step(0, 16'h0000, 0, 0, 0, 1, "R9 clear");
    step(1, 16'h0A01, 1, 0, 0, 0, "R4 busy write before boundary");
    step(1, 16'h2005, 1, 1, 0, 0, "R11 write at boundary stays pending");
    step(0, 16'h0000, 1, 1, 0, 0, "R11 later boundary applies new");
    step(0, 16'h0000, 1, 0, 1, 0, "R6 pending clears at queue end");
    step(0, 16'h0000, 0, 0, 0, 0, "R7 idle hold");
    repeat (3) @(posedge clk);
    #6;
    checks++;
    if (actEndPtr !== mActive[11:8] || actNewPtr !== mActive[3:0] || actIrqEn !== mActive[15]) begin
      errors++;
      $display("FAIL R2 field outputs: end=%h new=%h irq=%b expected end=%h new=%h irq=%b",
               actEndPtr, actNewPtr, actIrqEn, mActive[11:8], mActive[3:0], mActive[15]);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule